// File: doc/BRIEF.md
# Tournament branch direction predictor

This block predicts whether a conditional branch is taken. Two component predictors work side by side. The first is a per-address two-level path. A table of 10-bit local histories, selected by PC bits, supplies the index into a table of 3-bit saturating counters. The second is a global path, in which a 12-bit global outcome history selects one of 4096 2-bit saturating counters. A choice table of 2-bit counters, also selected by the global history, decides which of the two component predictions becomes the final answer.

The front end raises a predict strobe together with the branch PC. One cycle later it receives the final direction, both component predictions and the choice counter value. When the branch resolves, the back end presents the PC, the actual outcome and the two component predictions it recorded at predict time. The block then trains its counters and shifts the histories.

Top module: `tourn_pred`

## Requirements
- R1: A predict strobe sampled at a clock edge raises `pred_valid_o` for exactly the following cycle, with the prediction outputs valid in that cycle. Without a strobe, `pred_valid_o` is low and the prediction outputs keep their last values.
- R2: The local prediction comes from a two-step lookup. PC[11:2] selects a 10-bit local history. That history selects a 3-bit counter, and the counter's MSB is `local_pred_o` (1 = taken).
- R3: The 12-bit global history selects one of 4096 2-bit counters, and that counter's MSB is `global_pred_o`.
- R4: The global history also selects a 2-bit choice counter, which appears on `choice_o`. A choice MSB of 1 selects the global prediction and 0 selects the local one.
- R5: On an update, the local history entry for PC[11:2] shifts left and takes the outcome into bit 0. The global history does the same. With no update, both histories hold.
- R6: `pred_taken_o` equals the component prediction chosen by the choice MSB.
- R7: Every update trains both component counters, whichever one was selected. The local counter is the one addressed by the entry's current local history, and the global counter is the one addressed by the current global history. A taken outcome increments the counter and a not-taken outcome decrements it, saturating at 0 and at the maximum (7 for local, 3 for global).
- R8: The choice counter at the current global history changes only when the recorded local and global predictions differ. It increments when the global prediction matched the outcome and decrements otherwise, saturating at 0 and 3.
- R9: After reset, all local histories and the global history are 0, local counters are 3, global counters are 1 and choice counters are 1. The first prediction is therefore not taken, the local component is selected and `choice_o` is 1.
- R10: A predict and an update in the same cycle: the prediction uses the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_valid_i | input | 1 | Predict strobe |
| pred_pc_i | input | 32 | PC of the branch being predicted |
| pred_valid_o | output | 1 | Prediction outputs valid |
| pred_taken_o | output | 1 | Final direction (1 = taken) |
| local_pred_o | output | 1 | Local component prediction |
| global_pred_o | output | 1 | Global component prediction |
| choice_o | output | 2 | Choice counter value |
| upd_valid_i | input | 1 | Update strobe |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_local_pred_i | input | 1 | Local prediction recorded at predict time |
| upd_global_pred_i | input | 1 | Global prediction recorded at predict time |

## Verification
Each prediction is due in the cycle after its strobe is sampled. Each update changes the state at the edge where it is sampled, so the first prediction that can observe the update is one strobed at the next edge. Its result appears one cycle after that. The bench drives inputs on the falling edge and advances a behavioural model at each rising edge. The model produces the expected outputs from the pre-update state and then applies the update. All outputs are compared on the following falling edge, and this timing is what R10 requires. Directed sequences reach the reset state, saturation of every counter kind and a fully taken global history. The hand-computed values for those sequences are checked alongside the model.

// File: rtl/tourn_pkg.sv
package tourn_pkg;
  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_INC  = 2'd1,
    CTR_DEC  = 2'd2
  } ctr_op_e;

  function automatic ctr_op_e train_op(input logic en, input logic taken);
    if (!en) return CTR_HOLD;
    return taken ? CTR_INC : CTR_DEC;
  endfunction
endpackage

// File: rtl/sat_ctr_table.sv
module sat_ctr_table
  import tourn_pkg::*;
#(
  parameter int W  = 2,
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_ctr_o,
  input  logic [AW-1:0] wr_idx_i,
  input  ctr_op_e       op_i
);
  localparam int DEPTH = 1 << AW;
  localparam logic [W-1:0] MAX_V = {W{1'b1}};
  // weakly not-taken: MSB clear, all lower bits set
  localparam logic [W-1:0] RST_V = MAX_V >> 1;

  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] cur, nxt;

  assign rd_ctr_o = mem_q[rd_idx_i];
  assign cur      = mem_q[wr_idx_i];

  always_comb begin
    nxt = cur;
    unique case (op_i)
      CTR_INC: if (cur != MAX_V) nxt = cur + 1'b1;
      CTR_DEC: if (cur != '0)    nxt = cur - 1'b1;
      default: nxt = cur;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_V;
    end else if (op_i != CTR_HOLD) begin
      mem_q[wr_idx_i] <= nxt;
    end
  end
endmodule

// File: rtl/hist_table.sv
module hist_table #(
  parameter int HW = 10,
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] pred_idx_i,
  output logic [HW-1:0] pred_hist_o,
  input  logic [AW-1:0] upd_idx_i,
  output logic [HW-1:0] upd_hist_o,
  input  logic          upd_en_i,
  input  logic          upd_bit_i
);
  localparam int DEPTH = 1 << AW;

  logic [HW-1:0] hist_q [DEPTH];

  assign pred_hist_o = hist_q[pred_idx_i];
  assign upd_hist_o  = hist_q[upd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (upd_en_i) begin
      hist_q[upd_idx_i] <= {upd_hist_o[HW-2:0], upd_bit_i};
    end
  end
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
  import tourn_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int LCTR_W  = 3,
  parameter int GHIST_W = 12,
  parameter int GCTR_W  = 2,
  parameter int CCTR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_valid_i,
  input  logic [PC_W-1:0]   pred_pc_i,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic              local_pred_o,
  output logic              global_pred_o,
  output logic [CCTR_W-1:0] choice_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  input  logic              upd_local_pred_i,
  input  logic              upd_global_pred_i
);
  localparam int PC_LSB = 2;
  localparam int PC_MSB = PC_LSB + LIDX_W - 1;

  logic [LIDX_W-1:0]  p_lidx, u_lidx;
  logic [LHIST_W-1:0] p_lhist, u_lhist;
  logic [LCTR_W-1:0]  p_lctr;
  logic [GCTR_W-1:0]  p_gctr;
  logic [CCTR_W-1:0]  p_cctr;
  logic [GHIST_W-1:0] ghr_q;
  ctr_op_e            l_op, g_op, c_op;
  logic               p_local, p_global, p_final;
  logic               unused_pc;

  assign p_lidx    = pred_pc_i[PC_MSB:PC_LSB];
  assign u_lidx    = upd_pc_i[PC_MSB:PC_LSB];
  assign unused_pc = ^{pred_pc_i[PC_W-1:PC_MSB+1], pred_pc_i[PC_LSB-1:0],
                       upd_pc_i[PC_W-1:PC_MSB+1], upd_pc_i[PC_LSB-1:0]};

  // training controls
  assign l_op = train_op(upd_valid_i, upd_taken_i);
  assign g_op = train_op(upd_valid_i, upd_taken_i);
  assign c_op = train_op(upd_valid_i && (upd_local_pred_i != upd_global_pred_i),
                         upd_global_pred_i == upd_taken_i);

  hist_table #(.HW(LHIST_W), .AW(LIDX_W)) u_lht (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pred_idx_i  (p_lidx),
    .pred_hist_o (p_lhist),
    .upd_idx_i   (u_lidx),
    .upd_hist_o  (u_lhist),
    .upd_en_i    (upd_valid_i),
    .upd_bit_i   (upd_taken_i)
  );

  sat_ctr_table #(.W(LCTR_W), .AW(LHIST_W)) u_lct (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (p_lhist),
    .rd_ctr_o (p_lctr),
    .wr_idx_i (u_lhist),
    .op_i     (l_op)
  );

  sat_ctr_table #(.W(GCTR_W), .AW(GHIST_W)) u_gct (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (ghr_q),
    .rd_ctr_o (p_gctr),
    .wr_idx_i (ghr_q),
    .op_i     (g_op)
  );

  sat_ctr_table #(.W(CCTR_W), .AW(GHIST_W)) u_cct (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (ghr_q),
    .rd_ctr_o (p_cctr),
    .wr_idx_i (ghr_q),
    .op_i     (c_op)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ghr_q <= '0;
    else if (upd_valid_i) ghr_q <= {ghr_q[GHIST_W-2:0], upd_taken_i};
  end

  assign p_local  = p_lctr[LCTR_W-1];
  assign p_global = p_gctr[GCTR_W-1];
  assign p_final  = p_cctr[CCTR_W-1] ? p_global : p_local;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o  <= 1'b0;
      pred_taken_o  <= 1'b0;
      local_pred_o  <= 1'b0;
      global_pred_o <= 1'b0;
      choice_o      <= '0;
    end else begin
      pred_valid_o <= pred_valid_i;
      if (pred_valid_i) begin
        pred_taken_o  <= p_final;
        local_pred_o  <= p_local;
        global_pred_o <= p_global;
        choice_o      <= p_cctr;
      end
    end
  end
endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
  parameter int GHIST_W = 12,
  parameter int CCTR_W  = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pred_valid_i,
  input logic               pred_valid_o,
  input logic               pred_taken_o,
  input logic               local_pred_o,
  input logic               global_pred_o,
  input logic [CCTR_W-1:0]  choice_o,
  input logic               upd_valid_i,
  input logic               upd_taken_i,
  input logic [GHIST_W-1:0] ghr_q
);
  p_valid_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_i |=> pred_valid_o);

  p_valid_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_i |=> !pred_valid_o);

  p_outputs_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_i |=> ($stable(pred_taken_o) && $stable(choice_o)
                       && $stable(local_pred_o) && $stable(global_pred_o)));

  p_select_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> (pred_taken_o == (choice_o[CCTR_W-1] ? global_pred_o : local_pred_o)));

  p_ghr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghr_q));

  p_ghr_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (ghr_q[0] == $past(upd_taken_i)));
endmodule

bind tourn_pred tourn_pred_chk #(.GHIST_W(GHIST_W), .CCTR_W(CCTR_W)) u_tourn_pred_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pred_valid_i  (pred_valid_i),
  .pred_valid_o  (pred_valid_o),
  .pred_taken_o  (pred_taken_o),
  .local_pred_o  (local_pred_o),
  .global_pred_o (global_pred_o),
  .choice_o      (choice_o),
  .upd_valid_i   (upd_valid_i),
  .upd_taken_i   (upd_taken_i),
  .ghr_q         (ghr_q)
);

// File: tb/tourn_pred_bench.sv
`timescale 1ns/1ps
module tourn_pred_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_valid = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        upd_lp = 1'b0;
  logic        upd_gp = 1'b0;
  logic        o_valid, o_taken, o_local, o_global;
  logic [1:0]  o_choice;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string tag  = "R9";

  always #5 clk = ~clk;

  tourn_pred u_tourn_pred (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .pred_valid_i      (pred_valid),
    .pred_pc_i         (pred_pc),
    .pred_valid_o      (o_valid),
    .pred_taken_o      (o_taken),
    .local_pred_o      (o_local),
    .global_pred_o     (o_global),
    .choice_o          (o_choice),
    .upd_valid_i       (upd_valid),
    .upd_pc_i          (upd_pc),
    .upd_taken_i       (upd_taken),
    .upd_local_pred_i  (upd_lp),
    .upd_global_pred_i (upd_gp)
  );

  // behavioural reference state
  int m_lht [1024];
  int m_lct [1024];
  int m_gct [4096];
  int m_cht [4096];
  int m_ghr;
  int e_valid, e_taken, e_local, e_global, e_choice;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) begin m_lht[i] = 0; m_lct[i] = 3; end
      for (int i = 0; i < 4096; i++) begin m_gct[i] = 1; m_cht[i] = 1; end
      m_ghr = 0;
      e_valid = 0; e_taken = 0; e_local = 0; e_global = 0; e_choice = 0;
    end else begin
      // R10: prediction is formed from pre-update state
      e_valid = pred_valid;
      if (pred_valid) begin
        int h;
        h        = m_lht[(pred_pc >> 2) % 1024];
        e_local  = (m_lct[h] >= 4) ? 1 : 0;
        e_global = (m_gct[m_ghr] >= 2) ? 1 : 0;
        e_choice = m_cht[m_ghr];
        e_taken  = (e_choice >= 2) ? e_global : e_local;
      end
      if (upd_valid) begin
        int ui, h;
        ui = (upd_pc >> 2) % 1024;
        h  = m_lht[ui];
        if (upd_taken) begin
          if (m_lct[h] < 7) m_lct[h]++;
          if (m_gct[m_ghr] < 3) m_gct[m_ghr]++;
        end else begin
          if (m_lct[h] > 0) m_lct[h]--;
          if (m_gct[m_ghr] > 0) m_gct[m_ghr]--;
        end
        if (upd_lp != upd_gp) begin
          if (upd_gp == upd_taken) begin
            if (m_cht[m_ghr] < 3) m_cht[m_ghr]++;
          end else begin
            if (m_cht[m_ghr] > 0) m_cht[m_ghr]--;
          end
        end
        m_lht[ui] = ((h << 1) | int'(upd_taken)) % 1024;
        m_ghr     = ((m_ghr << 1) | int'(upd_taken)) % 4096;
      end
    end
  end

  task automatic check(string req, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s [%s] got %0d exp %0d", req, tag, got, exp);
    end
  endtask

  // model comparison on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1", int'(o_valid), e_valid);
      check("R2", int'(o_local), e_local);
      check("R3", int'(o_global), e_global);
      check("R4", int'(o_choice), e_choice);
      check("R6", int'(o_taken), e_taken);
    end
  end

  task automatic idle();
    pred_valid = 1'b0;
    upd_valid  = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset contents, first prediction
    tag = "R9";
    check("R1", int'(o_valid), 0);
    pred_valid = 1'b1; pred_pc = 32'h0000_0100;
    @(negedge clk);
    pred_valid = 1'b0;
    check("R9", int'(o_taken), 0);
    check("R9", int'(o_choice), 1);
    check("R9", int'(o_local), 0);
    check("R9", int'(o_global), 0);
    idle();

    // R7/R8: 20 taken updates with local wrong, global right, then predict
    tag = "R7 R8 saturation";
    for (int k = 0; k < 20; k++) begin
      upd_valid = 1'b1; upd_pc = 32'h40; upd_taken = 1'b1; upd_lp = 1'b0; upd_gp = 1'b1;
      @(negedge clk);
    end
    upd_valid = 1'b0;
    pred_valid = 1'b1; pred_pc = 32'h40;
    @(negedge clk);
    pred_valid = 1'b0;
    check("R7", int'(o_local), 1);
    check("R3", int'(o_global), 1);
    check("R8", int'(o_choice), 3);
    check("R6", int'(o_taken), 1);
    idle();

    // R5/R7: not-taken updates drive the same histories back down
    tag = "R5 R7 decrement";
    for (int k = 0; k < 16; k++) begin
      upd_valid = 1'b1; upd_pc = 32'h40; upd_taken = 1'b0; upd_lp = 1'b1; upd_gp = 1'b1;
      pred_valid = 1'b1; pred_pc = 32'h40;
      @(negedge clk);
    end
    idle();

    // R8/R10: mixed traffic on a small PC set, predicts and updates overlapping
    tag = "R5 R8 R10 mixed";
    for (int k = 0; k < 3000; k++) begin
      pred_valid = ($urandom % 4) != 0;
      pred_pc    = {20'h0, 8'($urandom % 16), 4'h0} | 32'($urandom % 4);
      upd_valid  = ($urandom % 3) != 0;
      upd_pc     = {20'h0, 8'($urandom % 16), 4'h0};
      upd_taken  = ($urandom % 5) != 0;
      upd_lp     = 1'($urandom);
      upd_gp     = 1'($urandom);
      @(negedge clk);
    end
    idle();
    idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog [%s] got 0 exp 1", tag);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule